// File: doc/BRIEF.md
# SPI Serial Clock Two-Stage Divider

This block derives the serial clock of an SPI master from the main clock with two dividers in series. The first stage is a power-of-two prescaler chosen by a 2-bit select (`div_i`). It yields a divide of 2, 4, 8 or 16. The second stage counts prescaler ticks and flips the serial clock after every `brg_i + 1` ticks. The serial clock period is therefore `2 * (brg_i + 1) * (2 << div_i)` main-clock cycles. This spans 20 cycles at the fastest legal setting and 2048 cycles at the slowest.

The clock only runs while `en_i` is high. While `en_i` is low, three things hold:
- `sck_o` sits at the idle level given by `cpol_i`.
- Both dividers are cleared.
- The select, divide and polarity inputs are captured into a configuration register.

While `en_i` is high, the captured configuration is frozen. Two single-cycle strobes come out with the clock, and the shift logic uses them: `lead_o` marks the move away from idle, and `trail_o` marks the return to idle.

Top module: `spi_sck_divider`

## Requirements
- R1: The prescaler stage produces one tick every `2 << div_i` main-clock cycles (2, 4, 8, 16 for `div_i` = 0..3).
- R2: Each half period of `sck_o` lasts `brg_i + 1` prescaler ticks. A full period is therefore `2*(brg_i+1)*(2<<div_i)` cycles: 20 at `div_i`=0, `brg_i`=4 and 2048 at `div_i`=3, `brg_i`=63.
- R3: A `brg_i` value below 4 behaves exactly like 4.
- R4: `div_i`, `brg_i` and `cpol_i` are captured only in cycles where `en_i` is low. Changes made while `en_i` is high do not affect the running clock and take effect after the next disable/enable.
- R5: One cycle after `en_i` is seen low, `sck_o` equals the idle level (`cpol_i`, 0 = idles low, 1 = idles high) and both strobes are low.
- R6: `lead_o` is high for exactly one cycle, in the cycle where `sck_o` first shows the non-idle level. `trail_o` is high for exactly one cycle, in the cycle where `sck_o` first shows the idle level again. The two strobes are never high together.
- R7: After `en_i` rises, the first leading edge appears exactly one half period (as in R2) after the first enabled clock edge, even if a previous run was cut off mid-period.
- R8: During reset `sck_o`, `lead_o` and `trail_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Runs the clock while high; idles, clears and loads configuration while low |
| cpol_i | input | 1 | Idle level of the serial clock |
| div_i | input | 2 | Power-of-two prescale select |
| brg_i | input | 6 | Half-period length in prescaler ticks, minus one (floor 4) |
| sck_o | output | 1 | Serial clock |
| lead_o | output | 1 | One-cycle strobe with the edge leaving idle |
| trail_o | output | 1 | One-cycle strobe with the edge returning to idle |

## Verification
The assertions assume that `en_i` is low through reset and in the first cycle after it. This keeps the frozen-configuration property from looking at an enable that predates reset. They also assume that `div_i`, `brg_i` and `cpol_i` carry known values whenever `en_i` is low. The stimulus changes every input only on the falling clock edge and keeps `en_i` low while reset is active. It leaves at least one disabled cycle before each enable, so the configuration register always holds the intended setting when a run starts.

// File: rtl/sck_div_pkg.sv
package sck_div_pkg;
    localparam int unsigned SEL_W_DEF   = 2;
    localparam int unsigned HALF_W_DEF  = 6;
    localparam int unsigned HALF_FLOOR  = 4;
endpackage

// File: rtl/sck_prescale.sv
module sck_prescale #(
    parameter int unsigned SEL_W = sck_div_pkg::SEL_W_DEF,
    localparam int unsigned CNT_W = 1 << SEL_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        last   = ~({CNT_W{1'b1}} << ({1'b0, sel_i} + {{SEL_W{1'b0}}, 1'b1}));
        tick_o = run_i && (st_q.cnt == last);
        st_d   = st_q;
        if (!run_i) begin
            st_d.cnt = '0;
        end else if (tick_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_PRE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (st_q.cnt <= last)); // R1
endmodule

// File: rtl/sck_halfdiv.sv
module sck_halfdiv #(
    parameter int unsigned HALF_W = sck_div_pkg::HALF_W_DEF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              tick_i,
    input  logic [HALF_W-1:0] span_i,
    output logic              flip_o
);
    typedef struct packed {
        logic [HALF_W-1:0] cnt;
    } half_st_t;

    half_st_t st_d, st_q;

    always_comb begin
        flip_o = tick_i && (st_q.cnt == span_i);
        st_d   = st_q;
        if (!run_i) begin
            st_d.cnt = '0;
        end else if (flip_o) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_HALF_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (st_q.cnt <= span_i)); // R2
endmodule

// File: rtl/sck_edge_gen.sv
module sck_edge_gen (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic flip_i,
    input  logic pol_cfg_i,
    input  logic idle_lvl_i,
    output logic sck_o,
    output logic lead_o,
    output logic trail_o
);
    typedef struct packed {
        logic sck;
        logic lead;
        logic trail;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.lead  = 1'b0;
        st_d.trail = 1'b0;
        if (!run_i) begin
            st_d.sck = idle_lvl_i;
        end else if (flip_i) begin
            st_d.sck   = ~st_q.sck;
            st_d.lead  = (st_q.sck == pol_cfg_i);
            st_d.trail = (st_q.sck != pol_cfg_i);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sck_o   = st_q.sck;
    assign lead_o  = st_q.lead;
    assign trail_o = st_q.trail;

    AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(st_q.lead && st_q.trail)); // R6
    AST_STROBE_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.lead || st_q.trail) |-> (st_q.sck != $past(st_q.sck))); // R6
    AST_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (st_q.sck == $past(idle_lvl_i)) && !st_q.lead && !st_q.trail); // R5
endmodule

// File: rtl/spi_sck_divider.sv
module spi_sck_divider #(
    parameter int unsigned SEL_W  = sck_div_pkg::SEL_W_DEF,
    parameter int unsigned HALF_W = sck_div_pkg::HALF_W_DEF,
    parameter int unsigned FLOOR  = sck_div_pkg::HALF_FLOOR
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              cpol_i,
    input  logic [SEL_W-1:0]  div_i,
    input  logic [HALF_W-1:0] brg_i,
    output logic              sck_o,
    output logic              lead_o,
    output logic              trail_o
);
    localparam logic [HALF_W-1:0] FLOOR_V = HALF_W'(FLOOR);

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [HALF_W-1:0] span;
        logic              pol;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic tick, flip;

    always_comb begin
        cfg_d = cfg_q;
        if (!en_i) begin
            cfg_d.sel  = div_i;
            cfg_d.span = (brg_i < FLOOR_V) ? FLOOR_V : brg_i;
            cfg_d.pol  = cpol_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cfg_q <= '{sel: '0, span: FLOOR_V, pol: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    sck_prescale #(.SEL_W(SEL_W)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (en_i),
        .sel_i  (cfg_q.sel),
        .tick_o (tick)
    );

    sck_halfdiv #(.HALF_W(HALF_W)) u_half (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (en_i),
        .tick_i (tick),
        .span_i (cfg_q.span),
        .flip_o (flip)
    );

    sck_edge_gen u_edge (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (en_i),
        .flip_i     (flip),
        .pol_cfg_i  (cfg_q.pol),
        .idle_lvl_i (cpol_i),
        .sck_o      (sck_o),
        .lead_o     (lead_o),
        .trail_o    (trail_o)
    );

    AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(en_i) |-> $stable(cfg_q)); // R4
    AST_SPAN_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_q.span >= FLOOR_V); // R3
endmodule

// File: tb/spi_sck_divider_test.sv
module spi_sck_divider_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       cpol = 1'b0;
    logic [1:0] div = 2'd0;
    logic [5:0] brg = 6'd4;
    logic       sck, lead, trail;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    spi_sck_divider uut (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cpol_i(cpol),
        .div_i(div), .brg_i(brg), .sck_o(sck), .lead_o(lead), .trail_o(trail)
    );

    // {div, brg, cpol, expected half period in main-clock cycles}
    localparam int NV = 8;
    localparam logic [19:0] VEC [NV] = '{
        {2'd0, 6'd4,  1'b0, 11'd10},
        {2'd1, 6'd4,  1'b1, 11'd20},
        {2'd2, 6'd9,  1'b0, 11'd80},
        {2'd3, 6'd63, 1'b1, 11'd1024},
        {2'd0, 6'd2,  1'b0, 11'd10},
        {2'd1, 6'd0,  1'b1, 11'd20},
        {2'd3, 6'd5,  1'b0, 11'd96},
        {2'd2, 6'd17, 1'b1, 11'd144}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // counts enabled edges until the wanted strobe shows; checks strobe width
    task automatic wait_strobe(input bit want_lead, output int n);
        n = 0;
        for (int i = 1; i <= 3000; i++) begin
            @(posedge clk);
            @(negedge clk);
            n = i;
            if (i == 1) check(!lead && !trail, "R6 strobe width", {lead, trail}, 0);
            if (want_lead ? lead : trail) begin
                check(!(lead && trail), "R6 exclusive", {lead, trail}, 1);
                break;
            end
        end
    endtask

    task automatic run_vec(input logic [1:0] d, input logic [5:0] b, input logic p, input int h);
        int n;
        en = 1'b0; div = d; brg = b; cpol = p;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        check(sck == p, "R5 idle level", sck, p);
        en = 1'b1;
        wait_strobe(1'b1, n);
        check(n == h, "R7 first lead delay", n, h);
        check(sck == ~p, "R6 lead level", sck, ~p);
        wait_strobe(1'b0, n);
        check(n == h, "R1 R2 R3 half period", n, h);
        check(sck == p, "R6 trail level", sck, p);
        wait_strobe(1'b1, n);
        check(n == h, "R2 second half", n, h);
        en = 1'b0;
        @(posedge clk); @(negedge clk);
        check(sck == p && !lead && !trail, "R5 disable", {sck, lead, trail}, {p, 2'b00});
    endtask

    initial begin
        #800000;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", total, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        @(negedge clk); @(negedge clk);
        check(!sck && !lead && !trail, "R8 reset", {sck, lead, trail}, 0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            run_vec(VEC[v][19:18], VEC[v][17:12], VEC[v][11], int'(VEC[v][10:0]));
        end

        // R4: changes while enabled are ignored until the next enable
        run_vec(2'd0, 6'd4, 1'b0, 10);
        en = 1'b1;
        wait_strobe(1'b1, n);
        div = 2'd3; brg = 6'd63; cpol = 1'b1;
        wait_strobe(1'b0, n);
        check(n == 10, "R4 frozen divide", n, 10);
        check(sck == 1'b0, "R4 frozen polarity", sck, 0);
        en = 1'b0;
        @(posedge clk); @(negedge clk);
        check(sck == 1'b1, "R5 new idle level", sck, 1);
        en = 1'b1;
        wait_strobe(1'b1, n);
        check(n == 1024, "R4 new setting applied", n, 1024);
        check(sck == 1'b0, "R4 new polarity", sck, 0);

        // R7: a run cut off mid-period restarts from a full half period
        en = 1'b0; div = 2'd0; brg = 6'd4; cpol = 1'b0;
        @(posedge clk); @(negedge clk);
        en = 1'b1;
        for (int i = 0; i < 6; i++) begin @(posedge clk); @(negedge clk); end
        en = 1'b0;
        @(posedge clk); @(negedge clk);
        check(sck == 1'b0, "R5 abort idle", sck, 0);
        en = 1'b1;
        wait_strobe(1'b1, n);
        check(n == 10, "R7 restart delay", n, 10);

        // R5: idle level follows polarity while disabled
        en = 1'b0; cpol = 1'b1;
        @(posedge clk); @(negedge clk);
        check(sck == 1'b1, "R5 follow high", sck, 1);
        cpol = 1'b0;
        @(posedge clk); @(negedge clk);
        check(sck == 1'b0, "R5 follow low", sck, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule